// File: doc/BRIEF.md
# Multi-Channel Block Transfer Engine (Single-Shot Mode)

The engine serves a set of transfer channels. Each channel is armed by software and started by a hardware trigger. One trigger moves one whole block of data units from a source address to a destination address over a simple memory bus. Each unit is moved as one bus read followed by one bus write. Software sets each channel's source and destination addresses, its block length in units, its count of triggers, its unit width (8, 16 or 32 bits) and, for source and destination separately, whether the address stays fixed or steps forward.

After a block, the stepped addresses and the count reduced by one are written back to the channel. The next trigger therefore continues where the last block ended. When the count reaches zero, the channel raises a one-cycle completion interrupt and clears its own enable bit, and later triggers on that channel are ignored. When several channels are waiting, the lowest-numbered one goes first. A block that has started runs to its end without interruption.

Top module: `dma_norm_engine`

## Requirements
- R1: After reset, neither bus valid is asserted, no interrupt is raised, and every channel field, including the enable bits, reads back as zero.
- R2: A trigger on an enabled channel moves exactly `blk` units. Each unit is a read at the current source address followed by a write at the current destination address. The write data equals the read data masked to the unit width. The size code on both buses is the control field bits [1:0]: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit (3 is stored as 2).
- R3: Control bit 2 makes the source address step and control bit 3 makes the destination address step. The step is 1, 2 or 4 bytes per unit, following the width. A cleared bit keeps that address fixed for the whole block.
- R4: After a block of N bytes, a stepping address reads back as its start value plus N, and a fixed address reads back unchanged.
- R5: Each completed block lowers the count field by one. When the count reaches zero, that channel's interrupt bit pulses high for exactly one cycle and its enable bit reads back as zero. At most one interrupt bit is high in any cycle.
- R6: A trigger on a disabled channel is dropped. Enabling the channel afterwards starts no transfer.
- R7: Among enabled channels with a pending trigger, the lowest-numbered one is served first. A started block is never interleaved with another channel's units.
- R8: A bus valid, once raised, stays high with a stable address (and stable write data) until ready is seen. Read valid and write valid are never high together.
- R9: Control bit 4 (repeat select) is stored and read back but has no effect on transfers.
- R10: A trigger on a channel in the same cycle that its final block completes is dropped along with every later one, so exactly one block runs.
- R11: Software access uses field select codes 0 = source address, 1 = destination address, 2 = block length, 3 = count, 4 = control, 5 = enable group. A write takes effect at the next clock edge, and reads are combinational. For code 5, the channel index port carries the group number g, and data bit k maps to channel 8g+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | NCH | Per-channel start request, sampled each cycle |
| cfg_we | input | 1 | Software write strobe |
| cfg_sel | input | 3 | Field select for writes |
| cfg_ch | input | CHW | Channel (or enable group) for writes |
| cfg_wdata | input | 32 | Software write data |
| cfg_rsel | input | 3 | Field select for reads |
| cfg_rch | input | CHW | Channel (or enable group) for reads |
| cfg_rdata | output | 32 | Read data |
| mrd_valid | output | 1 | Read request valid |
| mrd_ready | input | 1 | Read accepted, data present |
| mrd_addr | output | 32 | Read byte address |
| mrd_size | output | 2 | Read unit size code |
| mrd_rdata | input | 32 | Read data, right aligned |
| mwr_valid | output | 1 | Write request valid |
| mwr_ready | input | 1 | Write accepted |
| mwr_addr | output | 32 | Write byte address |
| mwr_size | output | 2 | Write unit size code |
| mwr_wdata | output | 32 | Write data, right aligned |
| irq | output | NCH | Per-channel completion pulse |

## Verification
The hard case is a channel's last block finishing while a trigger arrives for that same channel. In that one cycle the write-back clears the enable bit and the pending logic samples the trigger. The bench provokes this by holding a channel's trigger high for many cycles across its final block, with random wait states on both buses. The reference model expects exactly one block of reads and writes and one interrupt. Any further bus request, or a second interrupt, is reported as a failure.

// File: rtl/dma_norm_pkg.sv
package dma_norm_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;

  // software field select codes
  localparam logic [2:0] FLD_SRC = 3'd0;
  localparam logic [2:0] FLD_DST = 3'd1;
  localparam logic [2:0] FLD_BLK = 3'd2;
  localparam logic [2:0] FLD_CNT = 3'd3;
  localparam logic [2:0] FLD_CTL = 3'd4;
  localparam logic [2:0] FLD_ENA = 3'd5;

  // packed so that {rpt,dinc,sinc,uw} matches control bits [4:0]
  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  blk;
    logic [LEN_W-1:0]  cnt;
    logic              rpt;
    logic              dinc;
    logic              sinc;
    logic [1:0]        uw;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } xfer_st_e;

  function automatic logic [2:0] unit_bytes(input logic [1:0] uw);
    case (uw)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] unit_mask(input logic [1:0] uw);
    case (uw)
      2'd0:    return DATA_W'(32'h0000_00FF);
      2'd1:    return DATA_W'(32'h0000_FFFF);
      default: return DATA_W'(32'hFFFF_FFFF);
    endcase
  endfunction

endpackage

// File: rtl/dma_norm_regs.sv
module dma_norm_regs
  import dma_norm_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_sel,
  input  logic [CHW-1:0]         cfg_ch,
  input  logic [31:0]            cfg_wdata,
  input  logic                   upd_vld,
  input  logic [CHW-1:0]         upd_ch,
  input  logic [ADDR_W-1:0]      upd_src,
  input  logic [ADDR_W-1:0]      upd_dst,
  input  logic [LEN_W-1:0]       upd_cnt,
  input  logic                   upd_clr,
  output chan_cfg_t [NCH-1:0]    cfg_q,
  output logic [NCH-1:0]         en_q
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CHW-1:0] MY_CH  = CHW'(i);
    localparam logic [CHW-1:0] MY_GRP = CHW'(i / 8);
    localparam int             MY_BIT = i % 8;

    chan_cfg_t cfg_n;
    logic      en_n;

    always_comb begin
      cfg_n = cfg_q[i];
      en_n  = en_q[i];
      if (cfg_we && (cfg_ch == MY_CH)) begin
        case (cfg_sel)
          FLD_SRC: cfg_n.src = cfg_wdata[ADDR_W-1:0];
          FLD_DST: cfg_n.dst = cfg_wdata[ADDR_W-1:0];
          FLD_BLK: cfg_n.blk = cfg_wdata[LEN_W-1:0];
          FLD_CNT: cfg_n.cnt = cfg_wdata[LEN_W-1:0];
          FLD_CTL: begin
            cfg_n.uw   = (cfg_wdata[1:0] == 2'd3) ? 2'd2 : cfg_wdata[1:0];
            cfg_n.sinc = cfg_wdata[2];
            cfg_n.dinc = cfg_wdata[3];
            cfg_n.rpt  = cfg_wdata[4];
          end
          default: ;
        endcase
      end
      if (cfg_we && (cfg_sel == FLD_ENA) && (cfg_ch == MY_GRP)) begin
        en_n = cfg_wdata[MY_BIT];
      end
      // engine write-back wins over a software write in the same cycle
      if (upd_vld && (upd_ch == MY_CH)) begin
        cfg_n.src = upd_src;
        cfg_n.dst = upd_dst;
        cfg_n.cnt = upd_cnt;
        if (upd_clr) en_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
        en_q[i]  <= 1'b0;
      end else begin
        cfg_q[i] <= cfg_n;
        en_q[i]  <= en_n;
      end
    end
  end

endmodule

// File: rtl/dma_norm_arb.sv
module dma_norm_arb #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] clr_vec,
  input  logic           take,
  output logic           req_vld,
  output logic [CHW-1:0] req_ch
);

  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_n;
  logic [NCH-1:0] en_eff;
  logic [NCH-1:0] take_vec;
  logic [NCH-1:0] cand;

  always_comb begin
    en_eff   = en & ~clr_vec;
    take_vec = '0;
    if (take) take_vec[req_ch] = 1'b1;
    // a channel losing its enable this cycle drops its trigger too
    pend_n   = ((pend_q & ~take_vec) | trig) & en_eff;
  end

  always_comb begin
    cand    = pend_q & en_eff;
    req_vld = |cand;
    req_ch  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) req_ch = CHW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

endmodule

// File: rtl/dma_norm_xfer.sv
module dma_norm_xfer
  import dma_norm_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [CHW-1:0]    req_ch,
  input  logic [ADDR_W-1:0] sel_src,
  input  logic [ADDR_W-1:0] sel_dst,
  input  logic [LEN_W-1:0]  sel_blk,
  input  logic [LEN_W-1:0]  sel_cnt,
  input  logic [1:0]        sel_uw,
  input  logic              sel_sinc,
  input  logic              sel_dinc,
  output logic              take,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  output logic [1:0]        mrd_size,
  input  logic [DATA_W-1:0] mrd_rdata,
  output logic              mwr_valid,
  input  logic              mwr_ready,
  output logic [ADDR_W-1:0] mwr_addr,
  output logic [1:0]        mwr_size,
  output logic [DATA_W-1:0] mwr_wdata,
  output logic              upd_vld,
  output logic [CHW-1:0]    upd_ch,
  output logic [ADDR_W-1:0] upd_src,
  output logic [ADDR_W-1:0] upd_dst,
  output logic [LEN_W-1:0]  upd_cnt,
  output logic              upd_clr,
  output logic [NCH-1:0]    irq
);

  xfer_st_e          st_q, st_n;
  logic [CHW-1:0]    ch_q, ch_n;
  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n;
  logic [LEN_W-1:0]  rem_q, rem_n, cnt_q, cnt_n;
  logic [1:0]        uw_q, uw_n;
  logic              sinc_q, sinc_n, dinc_q, dinc_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic [NCH-1:0]    irq_q, irq_n;
  logic [ADDR_W-1:0] step;

  assign step = ADDR_W'(unit_bytes(uw_q));

  always_comb begin
    st_n   = st_q;
    ch_n   = ch_q;
    src_n  = src_q;
    dst_n  = dst_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    uw_n   = uw_q;
    sinc_n = sinc_q;
    dinc_n = dinc_q;
    dat_n  = dat_q;
    irq_n  = '0;
    take   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_vld) begin
          take   = 1'b1;
          ch_n   = req_ch;
          src_n  = sel_src;
          dst_n  = sel_dst;
          rem_n  = sel_blk;
          cnt_n  = sel_cnt;
          uw_n   = sel_uw;
          sinc_n = sel_sinc;
          dinc_n = sel_dinc;
          st_n   = ST_RD;
        end
      end
      ST_RD: begin
        if (mrd_ready) begin
          dat_n = mrd_rdata & unit_mask(uw_q);
          st_n  = ST_WR;
        end
      end
      ST_WR: begin
        if (mwr_ready) begin
          if (sinc_q) src_n = src_q + step;
          if (dinc_q) dst_n = dst_q + step;
          rem_n = rem_q - 1'b1;
          st_n  = (rem_q <= LEN_W'(1)) ? ST_DONE : ST_RD;
        end
      end
      ST_DONE: begin
        if (cnt_q <= LEN_W'(1)) irq_n[ch_q] = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      uw_q   <= '0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      dat_q  <= '0;
      irq_q  <= '0;
    end else begin
      st_q   <= st_n;
      ch_q   <= ch_n;
      src_q  <= src_n;
      dst_q  <= dst_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_n;
      uw_q   <= uw_n;
      sinc_q <= sinc_n;
      dinc_q <= dinc_n;
      dat_q  <= dat_n;
      irq_q  <= irq_n;
    end
  end

  assign mrd_valid = (st_q == ST_RD);
  assign mrd_addr  = src_q;
  assign mrd_size  = uw_q;
  assign mwr_valid = (st_q == ST_WR);
  assign mwr_addr  = dst_q;
  assign mwr_size  = uw_q;
  assign mwr_wdata = dat_q;
  assign upd_vld   = (st_q == ST_DONE);
  assign upd_ch    = ch_q;
  assign upd_src   = src_q;
  assign upd_dst   = dst_q;
  assign upd_cnt   = cnt_q - 1'b1;
  assign upd_clr   = (cnt_q <= LEN_W'(1));
  assign irq       = irq_q;

endmodule

// File: rtl/dma_norm_engine.sv
module dma_norm_engine
  import dma_norm_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NGRP = (NCH + 7) / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    trig,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [31:0]       cfg_wdata,
  input  logic [2:0]        cfg_rsel,
  input  logic [CHW-1:0]    cfg_rch,
  output logic [31:0]       cfg_rdata,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [ADDR_W-1:0] mrd_addr,
  output logic [1:0]        mrd_size,
  input  logic [DATA_W-1:0] mrd_rdata,
  output logic              mwr_valid,
  input  logic              mwr_ready,
  output logic [ADDR_W-1:0] mwr_addr,
  output logic [1:0]        mwr_size,
  output logic [DATA_W-1:0] mwr_wdata,
  output logic [NCH-1:0]    irq
);

  chan_cfg_t [NCH-1:0] cfg_q;
  logic [NCH-1:0]      en_q;
  logic                upd_vld, upd_clr, take, req_vld;
  logic [CHW-1:0]      upd_ch, req_ch;
  logic [ADDR_W-1:0]   upd_src, upd_dst;
  logic [LEN_W-1:0]    upd_cnt;
  logic [NCH-1:0]      clr_vec;
  chan_cfg_t           sel_cfg, rd_cfg;
  logic [NGRP*8-1:0]   en_pad;

  dma_norm_regs #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_ch    (cfg_ch),
    .cfg_wdata (cfg_wdata),
    .upd_vld   (upd_vld),
    .upd_ch    (upd_ch),
    .upd_src   (upd_src),
    .upd_dst   (upd_dst),
    .upd_cnt   (upd_cnt),
    .upd_clr   (upd_clr),
    .cfg_q     (cfg_q),
    .en_q      (en_q)
  );

  always_comb begin
    clr_vec = '0;
    if (upd_vld && upd_clr) clr_vec[upd_ch] = 1'b1;
  end

  dma_norm_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .en      (en_q),
    .clr_vec (clr_vec),
    .take    (take),
    .req_vld (req_vld),
    .req_ch  (req_ch)
  );

  always_comb begin
    sel_cfg = '0;
    if (int'(req_ch) < NCH) sel_cfg = cfg_q[req_ch];
  end

  dma_norm_xfer #(.NCH(NCH)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_ch    (req_ch),
    .sel_src   (sel_cfg.src),
    .sel_dst   (sel_cfg.dst),
    .sel_blk   (sel_cfg.blk),
    .sel_cnt   (sel_cfg.cnt),
    .sel_uw    (sel_cfg.uw),
    .sel_sinc  (sel_cfg.sinc),
    .sel_dinc  (sel_cfg.dinc),
    .take      (take),
    .mrd_valid (mrd_valid),
    .mrd_ready (mrd_ready),
    .mrd_addr  (mrd_addr),
    .mrd_size  (mrd_size),
    .mrd_rdata (mrd_rdata),
    .mwr_valid (mwr_valid),
    .mwr_ready (mwr_ready),
    .mwr_addr  (mwr_addr),
    .mwr_size  (mwr_size),
    .mwr_wdata (mwr_wdata),
    .upd_vld   (upd_vld),
    .upd_ch    (upd_ch),
    .upd_src   (upd_src),
    .upd_dst   (upd_dst),
    .upd_cnt   (upd_cnt),
    .upd_clr   (upd_clr),
    .irq       (irq)
  );

  // software read-back
  always_comb begin
    rd_cfg = '0;
    if (int'(cfg_rch) < NCH) rd_cfg = cfg_q[cfg_rch];
    en_pad = '0;
    en_pad[NCH-1:0] = en_q;
    cfg_rdata = '0;
    case (cfg_rsel)
      FLD_SRC: cfg_rdata = rd_cfg.src;
      FLD_DST: cfg_rdata = rd_cfg.dst;
      FLD_BLK: cfg_rdata = {{(32-LEN_W){1'b0}}, rd_cfg.blk};
      FLD_CNT: cfg_rdata = {{(32-LEN_W){1'b0}}, rd_cfg.cnt};
      FLD_CTL: cfg_rdata = {27'd0, rd_cfg.rpt, rd_cfg.dinc, rd_cfg.sinc, rd_cfg.uw};
      FLD_ENA: if (int'(cfg_rch) < NGRP) cfg_rdata = {24'd0, en_pad[int'(cfg_rch)*8 +: 8]};
      default: cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_norm_chk.sv
module dma_norm_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mrd_valid,
  input logic           mrd_ready,
  input logic [31:0]    mrd_addr,
  input logic           mwr_valid,
  input logic           mwr_ready,
  input logic [31:0]    mwr_addr,
  input logic [31:0]    mwr_wdata,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] en_q
);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && !mwr_ready) |=> (mwr_valid && $stable(mwr_addr) && $stable(mwr_wdata)));

  // R8
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrd_valid && mwr_valid));

  // R2
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mwr_valid) |-> $past(mrd_valid && mrd_ready));

  // R5
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  // R5
  irq_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> ((irq & en_q) == '0));

endmodule

bind dma_norm_engine dma_norm_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mrd_valid (mrd_valid),
  .mrd_ready (mrd_ready),
  .mrd_addr  (mrd_addr),
  .mwr_valid (mwr_valid),
  .mwr_ready (mwr_ready),
  .mwr_addr  (mwr_addr),
  .mwr_wdata (mwr_wdata),
  .irq       (irq),
  .en_q      (en_q)
);

// File: tb/sim_dma_norm_engine.sv
module sim_dma_norm_engine;

  localparam int NCH = 8;
  localparam int CHW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] trig = '0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_sel = '0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [2:0]     cfg_rsel = '0;
  logic [CHW-1:0] cfg_rch = '0;
  logic [31:0]    cfg_rdata;
  logic           mrd_valid, mwr_valid;
  logic           mrd_ready = 1'b0, mwr_ready = 1'b0;
  logic [31:0]    mrd_addr, mwr_addr, mwr_wdata;
  logic [31:0]    mrd_rdata = '0;
  logic [1:0]     mrd_size, mwr_size;
  logic [NCH-1:0] irq;

  always #5 clk = ~clk;

  dma_norm_engine #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel), .cfg_rch(cfg_rch), .cfg_rdata(cfg_rdata),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrd_size(mrd_size), .mrd_rdata(mrd_rdata),
    .mwr_valid(mwr_valid), .mwr_ready(mwr_ready), .mwr_addr(mwr_addr),
    .mwr_size(mwr_size), .mwr_wdata(mwr_wdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [31:0] data;
  } bus_t;

  int          nchk = 0;
  int          nerr = 0;
  bit          done = 0;
  logic [7:0]  mem [4096];
  bus_t        exp_q [$];
  logic [31:0] m_src [NCH];
  logic [31:0] m_dst [NCH];
  int          m_blk [NCH];
  int          m_cnt [NCH];
  logic [4:0]  m_ctl [NCH];
  logic [7:0]  m_en = '0;
  int          exp_irq [NCH];
  int          irq_seen [NCH];
  logic [7:0]  lfsr = 8'hA5;

  function automatic logic [31:0] memrd(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < (1 << sz); k++) v[8*k +: 8] = mem[(a + k) & 32'hFFF];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference: one triggered block of channel ch
  task automatic model_block(input int ch);
    int   nb = 1 << m_ctl[ch][1:0];
    bus_t e;
    for (int u = 0; u < m_blk[ch]; u++) begin
      e.wr = 1'b0; e.addr = m_src[ch]; e.sz = m_ctl[ch][1:0];
      e.data = memrd(m_src[ch], m_ctl[ch][1:0]);
      exp_q.push_back(e);
      e.wr = 1'b1; e.addr = m_dst[ch];
      exp_q.push_back(e);
      if (m_ctl[ch][2]) m_src[ch] += nb;
      if (m_ctl[ch][3]) m_dst[ch] += nb;
    end
    m_cnt[ch]--;
    if (m_cnt[ch] == 0) begin
      m_en[ch] = 1'b0;
      exp_irq[ch]++;
    end
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input int ch, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_ch = CHW'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input int blk, input int cnt, input logic [4:0] ctl);
    m_src[ch] = s; m_dst[ch] = d; m_blk[ch] = blk; m_cnt[ch] = cnt; m_ctl[ch] = ctl;
    cfg_wr(3'd0, ch, s);
    cfg_wr(3'd1, ch, d);
    cfg_wr(3'd2, ch, blk);
    cfg_wr(3'd3, ch, cnt);
    cfg_wr(3'd4, ch, {27'd0, ctl});
  endtask

  task automatic rd_chk(input logic [2:0] sel, input int ch, input logic [31:0] exp,
                        input string req, input string what);
    @(negedge clk);
    cfg_rsel = sel; cfg_rch = CHW'(ch);
    #1;
    chk(cfg_rdata == exp, req, what, cfg_rdata, exp);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic irq_chk(input string req);
    for (int c = 0; c < NCH; c++)
      chk(irq_seen[c] == exp_irq[c], req, $sformatf("irq count ch%0d", c),
          irq_seen[c], exp_irq[c]);
  endtask

  // bus responder and per-clock comparison with the reference queue
  always @(negedge clk) begin
    if (rst_n) begin
      bus_t e;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mrd_ready = lfsr[0] | lfsr[1];
      mwr_ready = lfsr[2] | lfsr[3];
      for (int c = 0; c < NCH; c++) if (irq[c]) irq_seen[c]++;
      if (mrd_valid && mrd_ready) begin
        mrd_rdata = memrd(mrd_addr, mrd_size);
        if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected read", mrd_addr, 32'h0);
        else begin
          e = exp_q.pop_front();
          chk(!e.wr, "R8", "read where write due", {31'd0, e.wr}, 32'd1);
          chk(mrd_addr == e.addr, "R3", "read address", mrd_addr, e.addr);
          chk(mrd_size == e.sz, "R2", "read size", {30'd0, mrd_size}, {30'd0, e.sz});
        end
      end
      if (mwr_valid && mwr_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected write", mwr_addr, 32'h0);
        else begin
          e = exp_q.pop_front();
          chk(e.wr, "R8", "write where read due", {31'd0, e.wr}, 32'd1);
          chk(mwr_addr == e.addr, "R3", "write address", mwr_addr, e.addr);
          chk(mwr_wdata == e.data, "R2", "write data", mwr_wdata, e.data);
          chk(mwr_size == e.sz, "R2", "write size", {30'd0, mwr_size}, {30'd0, e.sz});
        end
        for (int k = 0; k < (1 << mwr_size); k++)
          mem[(mwr_addr + k) & 32'hFFF] = mwr_wdata[8*k +: 8];
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    for (int c = 0; c < NCH; c++) begin
      exp_irq[c] = 0; irq_seen[c] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk(!mrd_valid && !mwr_valid, "R1", "bus idle in reset", {30'd0, mrd_valid, mwr_valid}, 0);
    chk(irq == '0, "R1", "irq in reset", {24'd0, irq}, 0);
    rst_n = 1'b1;
    rd_chk(3'd0, 0, 32'h0, "R1", "src after reset");
    rd_chk(3'd3, 3, 32'h0, "R1", "count after reset");
    rd_chk(3'd5, 0, 32'h0, "R1", "enables after reset");

    // R2 R3 R4 R5 R9 R11: 16-bit, fixed source, stepping destination, repeat bit set
    prog(1, 32'h100, 32'h400, 3, 1, 5'h19);
    rd_chk(3'd4, 1, 32'h19, "R11", "control read-back");
    m_en[1] = 1'b1; cfg_wr(3'd5, 0, {24'd0, m_en});
    model_block(1);
    @(negedge clk); trig[1] = 1'b1; @(negedge clk); trig = '0;
    drain();
    rd_chk(3'd0, 1, 32'h100, "R4", "fixed source kept");
    rd_chk(3'd1, 1, 32'h406, "R4", "destination plus N");
    rd_chk(3'd3, 1, 32'h0, "R5", "count reached zero");
    rd_chk(3'd5, 0, {24'd0, m_en}, "R5", "enable cleared");
    irq_chk("R5");

    // R7 priority: three channels triggered together
    prog(0, 32'h200, 32'h500, 4, 2, 5'h0C);
    prog(2, 32'h300, 32'h600, 3, 1, 5'h0E);
    prog(3, 32'h380, 32'h700, 5, 1, 5'h04);
    m_en[0] = 1'b1; m_en[2] = 1'b1; m_en[3] = 1'b1;
    cfg_wr(3'd5, 0, {24'd0, m_en});
    model_block(0); model_block(2); model_block(3);
    @(negedge clk); trig = 8'b0000_1101; @(negedge clk); trig = '0;
    drain();
    rd_chk(3'd0, 0, 32'h204, "R4", "ch0 source");
    rd_chk(3'd1, 0, 32'h504, "R4", "ch0 destination");
    rd_chk(3'd3, 0, 32'h1, "R5", "ch0 count one left");
    rd_chk(3'd1, 2, 32'h60C, "R4", "ch2 destination 32-bit");
    rd_chk(3'd0, 3, 32'h385, "R4", "ch3 source 8-bit");
    rd_chk(3'd1, 3, 32'h700, "R3", "ch3 fixed destination");
    rd_chk(3'd5, 0, {24'd0, m_en}, "R5", "only ch0 still enabled");
    irq_chk("R7");

    // R6 trigger on a disabled channel is dropped
    prog(5, 32'h120, 32'h800, 2, 1, 5'h0C);
    @(negedge clk); trig[5] = 1'b1; @(negedge clk); trig = '0;
    m_en[5] = 1'b1; cfg_wr(3'd5, 0, {24'd0, m_en});
    repeat (30) @(negedge clk);
    drain();
    rd_chk(3'd3, 5, 32'h1, "R6", "ch5 count untouched");
    irq_chk("R6");

    // R10 trigger held across the final block's completion
    model_block(0);
    @(negedge clk); trig[0] = 1'b1;
    repeat (80) @(negedge clk);
    trig = '0;
    drain();
    rd_chk(3'd3, 0, 32'h0, "R10", "ch0 count");
    rd_chk(3'd5, 0, {24'd0, m_en}, "R10", "ch0 disabled");
    irq_chk("R10");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule